// File: doc/BRIEF.md
# Masked Interrupt Status Controller

The block gathers six DMA event lines and a parameterised group of user event lines into two status registers. Each status register has its own mask register. A software register port gives access to all four registers. The block tells the host about pending events in one of two ways, chosen by a mode input. In legacy mode it drives a level interrupt, and software clears status bits by writing ones to them. In message mode it drives a request/acknowledge handshake to a message generator, and each status bit clears itself once its message has been acknowledged.

All event inputs are active high and go through rising-edge detection. A one-cycle pulse and a held level therefore each record one event. User events are coalesced. After the handler services the user status register, only the first new unmasked user event produces an interrupt. Events that arrive later are recorded in status but raise nothing more until the next service.

Top module: `irq_status_ctrl`

## Requirements
- R1: After synchronous reset, all status and mask registers read 0, `irq_level` and `msg_req` are 0, and user coalescing is armed.
- R2: A rising edge on an event input sets its status bit on the next clock. A level held high sets the bit only once, so a bit cleared while its input stays high stays cleared. DMA status bit order is: bit 0 engine 0 to-host, bit 1 engine 0 from-host, bit 2 engine 1 to-host, bit 3 engine 1 from-host, bit 4 engine 0 going idle, bit 5 engine 1 going idle.
- R3: Register addresses are 0 for DMA status, 1 for DMA mask, 2 for user status and 3 for user mask. `reg_rdata` returns the register at `reg_addr` one clock after the address is presented, with unused upper bits read as 0.
- R4: In legacy mode, writing 1 to a status bit clears it and writing 0 leaves it unchanged. When a new edge and a clearing write hit the same bit in the same cycle, the bit stays set.
- R5: A status bit whose mask bit is 0 still records its event but raises neither `irq_level` nor `msg_req`.
- R6: After a service, only the first new unmasked user event raises an interrupt. Further user events until the next service only set status. A service is any write to address 2. It re-arms coalescing, and in legacy mode it also drops the user interrupt. User bits still set from before a service do not raise a new interrupt.
- R7: `irq_level` is a registered output. It is 1 exactly when the mode is legacy and either a DMA status bit is set under its mask or a user interrupt is outstanding. In message mode it is always 0.
- R8: In message mode, `msg_req` rises with `msg_vec` set to the lowest-numbered source that is pending. DMA bit i uses vector i, and the user group uses vector 6. `msg_req` and `msg_vec` hold until `msg_ack`. The acknowledge clears that DMA bit, or clears all masked user bits. Register writes do not clear status in message mode.
- R9: `msg_req` falls on the clock after it is acknowledged and stays low for at least one cycle before the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_mode | input | 1 | 0 selects legacy level signalling, 1 selects message handshake |
| dma_evt | input | 6 | DMA event lines, bit order as in R2 |
| usr_evt | input | 4 | User event lines |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 6 | Write data |
| reg_rdata | output | 6 | Registered read data |
| irq_level | output | 1 | Legacy interrupt level |
| msg_req | output | 1 | Message request |
| msg_vec | output | 3 | Source number of the current request |
| msg_ack | input | 1 | Message sent acknowledge |

## Verification
Single pulses, held levels and simultaneous multi-bit edges separate edge detection from level sampling. A clearing write that coincides with a new edge shows which of the two takes priority. Bursts of user events between service writes show whether coalescing issues exactly one interrupt per window and whether bits left pending stay quiet after re-arming. Message-mode runs with delayed, immediate and random acknowledges, together with mode flips, are compared on every clock with a behavioural model, which checks vector priority, request hold and self-clearing.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    REG_DSTAT = 2'd0,
    REG_DMASK = 2'd1,
    REG_USTAT = 2'd2,
    REG_UMASK = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_event_latch.sv
module irq_event_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] stat_q;

  assign rise_o = evt_i & ~prev_q;
  assign stat_o = stat_q;

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) begin
          prev_q[b] <= 1'b0;
          stat_q[b] <= 1'b0;
        end else begin
          prev_q[b] <= evt_i[b];
          // a fresh edge outranks a clear in the same cycle
          stat_q[b] <= (stat_q[b] & ~clr_i[b]) | rise_o[b];
        end
      end
    end
  endgenerate

  // R2: a status bit only appears where the input was high one cycle earlier
  assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ~$past(stat_q) & ~$past(evt_i)) == '0));
endmodule

// File: rtl/irq_user_coalesce.sv
module irq_user_coalesce #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         msg_mode_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] mask_i,
  input  logic         service_i,
  input  logic         ack_i,
  output logic         pend_o
);
  logic armed_q;
  logic pend_q;
  logic fire;

  assign fire   = armed_q & (|(rise_i & mask_i));
  assign pend_o = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b1;
      pend_q  <= 1'b0;
    end else if (fire) begin
      armed_q <= 1'b0;
      pend_q  <= 1'b1;
    end else begin
      if (service_i) armed_q <= 1'b1;
      if ((service_i && !msg_mode_i) || (ack_i && msg_mode_i)) pend_q <= 1'b0;
    end
  end

  // R6: no new user interrupt while coalescing is disarmed
  assert_single_fire_R6: assert property (@(posedge clk) disable iff (rst)
    !armed_q |=> !$rose(pend_q));
endmodule

// File: rtl/irq_msg_port.sv
module irq_msg_port #(
  parameter int N     = 7,
  parameter int VEC_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [N-1:0]     cand_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [N-1:0]     done_o
);
  logic             req_q;
  logic [VEC_W-1:0] vec_q;
  logic [VEC_W-1:0] pick;
  logic             any;

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        pick = VEC_W'(i);
        any  = 1'b1;
      end
    end
  end

  always_comb begin
    done_o = '0;
    if (req_q && ack_i && en_i) begin
      for (int i = 0; i < N; i++) begin
        if (vec_q == VEC_W'(i)) done_o[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else if (!en_i) begin
      req_q <= 1'b0;
    end else if (req_q) begin
      if (ack_i) req_q <= 1'b0;
    end else if (any) begin
      req_q <= 1'b1;
      vec_q <= pick;
    end
  end

  assign req_o = req_q;
  assign vec_o = vec_q;

  // R8: an open request and its vector hold until acknowledged
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (req_q && !ack_i && en_i) |=> (req_q && $stable(vec_q)));
  // R8: vector always names an existing source
  assert_vec_range_R8: assert property (@(posedge clk) disable iff (rst)
    req_q |-> (int'(vec_q) < N));
  // R9: acknowledged request drops on the next clock
  assert_req_gap_R9: assert property (@(posedge clk) disable iff (rst)
    (req_q && ack_i) |=> !req_q);
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int DMA_W  = 6,
  parameter int USER_W = 4,
  localparam int REG_W = (DMA_W > USER_W) ? DMA_W : USER_W,
  localparam int N_SRC = DMA_W + 1,
  localparam int VEC_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_mode,
  input  logic [DMA_W-1:0]  dma_evt,
  input  logic [USER_W-1:0] usr_evt,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_level,
  input  logic              msg_ack,
  output logic              msg_req,
  output logic [VEC_W-1:0]  msg_vec
);
  import irq_pkg::*;

  logic [DMA_W-1:0]  dstat, drise, dclr, dmask_q;
  logic [USER_W-1:0] ustat, urise, uclr, umask_q;
  logic [N_SRC-1:0]  cand, done;
  logic              upend;
  logic              wr_dstat, wr_ustat, legacy;

  assign legacy   = ~msg_mode;
  assign wr_dstat = reg_wr && (reg_sel_e'(reg_addr) == REG_DSTAT);
  assign wr_ustat = reg_wr && (reg_sel_e'(reg_addr) == REG_USTAT);

  assign dclr = ((legacy && wr_dstat) ? reg_wdata[DMA_W-1:0] : '0) | done[DMA_W-1:0];
  assign uclr = ((legacy && wr_ustat) ? reg_wdata[USER_W-1:0] : '0)
              | (done[DMA_W] ? umask_q : '0);

  irq_event_latch #(.W(DMA_W)) u_dma_lat (
    .clk(clk), .rst(rst), .evt_i(dma_evt), .clr_i(dclr),
    .stat_o(dstat), .rise_o(drise)
  );

  irq_event_latch #(.W(USER_W)) u_usr_lat (
    .clk(clk), .rst(rst), .evt_i(usr_evt), .clr_i(uclr),
    .stat_o(ustat), .rise_o(urise)
  );

  irq_user_coalesce #(.W(USER_W)) u_coal (
    .clk(clk), .rst(rst), .msg_mode_i(msg_mode), .rise_i(urise),
    .mask_i(umask_q), .service_i(wr_ustat), .ack_i(done[DMA_W]),
    .pend_o(upend)
  );

  assign cand = {upend, dstat & dmask_q};

  irq_msg_port #(.N(N_SRC), .VEC_W(VEC_W)) u_msg (
    .clk(clk), .rst(rst), .en_i(msg_mode), .cand_i(cand), .ack_i(msg_ack),
    .req_o(msg_req), .vec_o(msg_vec), .done_o(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dmask_q   <= '0;
      umask_q   <= '0;
      irq_level <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_sel_e'(reg_addr) == REG_DMASK) dmask_q <= reg_wdata[DMA_W-1:0];
      if (reg_wr && reg_sel_e'(reg_addr) == REG_UMASK) umask_q <= reg_wdata[USER_W-1:0];
      irq_level <= legacy && ((|(dstat & dmask_q)) || upend);
      reg_rdata <= '0;
      case (reg_sel_e'(reg_addr))
        REG_DSTAT: reg_rdata[DMA_W-1:0]  <= dstat;
        REG_DMASK: reg_rdata[DMA_W-1:0]  <= dmask_q;
        REG_USTAT: reg_rdata[USER_W-1:0] <= ustat;
        default:   reg_rdata[USER_W-1:0] <= umask_q;
      endcase
    end
  end

  // R7: message mode keeps the level line quiet
  assert_quiet_msg_R7: assert property (@(posedge clk) disable iff (rst)
    msg_mode |=> !irq_level);
  // R5: nothing enabled and pending means no level interrupt
  assert_mask_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (((dstat & dmask_q) == '0) && !upend) |=> !irq_level);
endmodule

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  localparam int DW = 6, UW = 4, RW = 6, VW = 3;

  logic clk = 1'b0, rst = 1'b1, msg_mode = 1'b0, reg_wr = 1'b0, msg_ack = 1'b0;
  logic [DW-1:0] dma_evt = '0;
  logic [UW-1:0] usr_evt = '0;
  logic [1:0]    reg_addr = '0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic          irq_level, msg_req;
  logic [VW-1:0] msg_vec;

  irq_status_ctrl dut (
    .clk(clk), .rst(rst), .msg_mode(msg_mode), .dma_evt(dma_evt), .usr_evt(usr_evt),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_level(irq_level), .msg_ack(msg_ack), .msg_req(msg_req), .msg_vec(msg_vec)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit auto_ack = 0, rand_ack = 0;

  // behavioural reference model
  logic [DW-1:0] m_dprev, m_dstat, m_dmask;
  logic [UW-1:0] m_uprev, m_ustat, m_umask;
  bit m_armed, m_upend, m_req, m_irq;
  int m_vec;
  logic [RW-1:0] m_rdata;

  always @(posedge clk) begin : model
    logic [DW-1:0] dr, dclr;
    logic [UW-1:0] ur, uclr;
    bit hit, svc, fire, nreq;
    int nvec;
    if (rst) begin
      m_dprev = 0; m_dstat = 0; m_dmask = 0; m_uprev = 0; m_ustat = 0; m_umask = 0;
      m_armed = 1; m_upend = 0; m_req = 0; m_irq = 0; m_vec = 0; m_rdata = 0;
    end else begin
      dr = dma_evt & ~m_dprev;
      ur = usr_evt & ~m_uprev;
      case (reg_addr)
        2'd0: m_rdata = m_dstat;
        2'd1: m_rdata = m_dmask;
        2'd2: m_rdata = {2'b00, m_ustat};
        default: m_rdata = {2'b00, m_umask};
      endcase
      m_irq = !msg_mode && (((m_dstat & m_dmask) != 0) || m_upend);
      hit = m_req && msg_ack && msg_mode;
      dclr = 0; uclr = 0;
      if (!msg_mode && reg_wr && reg_addr == 2'd0) dclr = reg_wdata;
      if (!msg_mode && reg_wr && reg_addr == 2'd2) uclr = reg_wdata[UW-1:0];
      if (hit) begin
        if (m_vec < DW) dclr[m_vec] = 1'b1;
        else uclr = uclr | m_umask;
      end
      svc  = reg_wr && reg_addr == 2'd2;
      fire = m_armed && ((ur & m_umask) != 0);
      nreq = 0; nvec = m_vec;
      if (msg_mode) begin
        if (m_req) nreq = !msg_ack;
        else begin
          for (int i = DW; i >= 0; i--) begin
            if ((i < DW) ? (m_dstat[i] && m_dmask[i]) : m_upend) begin
              nreq = 1; nvec = i;
            end
          end
        end
      end
      if (fire) begin
        m_armed = 0; m_upend = 1;
      end else begin
        if (svc) m_armed = 1;
        if (svc && !msg_mode) m_upend = 0;
        if (hit && m_vec == DW) m_upend = 0;
      end
      m_dstat = (m_dstat & ~dclr) | dr;
      m_ustat = (m_ustat & ~uclr) | ur;
      m_dprev = dma_evt; m_uprev = usr_evt;
      if (reg_wr && reg_addr == 2'd1) m_dmask = reg_wdata;
      if (reg_wr && reg_addr == 2'd3) m_umask = reg_wdata[UW-1:0];
      m_req = nreq; m_vec = nvec;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R7 irq_level vs model", int'(irq_level), int'(m_irq));
      chk("R8 msg_req vs model", int'(msg_req), int'(m_req));
      if (m_req) chk("R8 msg_vec vs model", int'(msg_vec), m_vec);
      chk("R3 reg_rdata vs model", int'(reg_rdata), int'(m_rdata));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [RW-1:0] d);
    @(negedge clk); #1 reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk); #1 reg_addr = a;
    @(negedge clk); v = int'(reg_rdata);
  endtask

  task automatic pulse_d(input logic [DW-1:0] b);
    @(negedge clk); #1 dma_evt = b;
    @(negedge clk); #1 dma_evt = '0;
  endtask

  task automatic pulse_u(input logic [UW-1:0] b);
    @(negedge clk); #1 usr_evt = b;
    @(negedge clk); #1 usr_evt = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk); #1;
      if (auto_ack) msg_ack = msg_req && !msg_ack;
      else if (rand_ack) msg_ack = ($urandom % 3) == 0;
    end
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int v;
    idle(3);
    @(negedge clk); #1 rst = 0;
    // R1 reset state
    chk("R1 irq_level", int'(irq_level), 0);
    chk("R1 msg_req", int'(msg_req), 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 register reads zero", v, 0);
    end
    // R2 / R5: masked-off event recorded, no interrupt
    pulse_d(6'h04); idle(2);
    rd(2'd0, v); chk("R2 engine1 to-host bit", v, 'h04);
    chk("R5 masked event raises no irq", int'(irq_level), 0);
    wr(2'd1, 6'h04); idle(2);
    chk("R7 unmasked event raises irq", int'(irq_level), 1);
    // R4: zero write no effect, one write clears
    wr(2'd0, 6'h00); rd(2'd0, v); chk("R4 zero write keeps bit", v, 'h04);
    wr(2'd0, 6'h04); idle(2);
    rd(2'd0, v); chk("R4 one write clears bit", v, 0);
    chk("R7 irq drops after clear", int'(irq_level), 0);
    // R2: held level sets once
    @(negedge clk); #1 dma_evt = 6'h01;
    idle(3);
    wr(2'd0, 6'h01); idle(3);
    rd(2'd0, v); chk("R2 held level does not re-set", v, 0);
    @(negedge clk); #1 dma_evt = 6'h00;
    // R4: edge and clear in the same cycle
    pulse_d(6'h02);
    @(negedge clk); #1 dma_evt = 6'h02; reg_wr = 1; reg_addr = 2'd0; reg_wdata = 6'h02;
    @(negedge clk); #1 dma_evt = 6'h00; reg_wr = 0;
    rd(2'd0, v); chk("R4 new edge wins over clear", v, 'h02);
    // R6: user coalescing in legacy mode
    wr(2'd1, 6'h00); wr(2'd3, 6'h0F); idle(2);
    pulse_u(4'h1); idle(2);
    chk("R6 first user event raises irq", int'(irq_level), 1);
    pulse_u(4'h2); idle(2);
    wr(2'd2, 6'h01); idle(2);
    chk("R6 service drops irq though bit1 pending", int'(irq_level), 0);
    rd(2'd2, v); chk("R6 user status after service", v, 'h2);
    idle(3);
    chk("R6 old pending stays quiet", int'(irq_level), 0);
    pulse_u(4'h4); idle(2);
    chk("R6 re-armed user event raises irq", int'(irq_level), 1);
    // prepare message mode
    wr(2'd2, 6'h0F); wr(2'd0, 6'h3F);
    @(negedge clk); #1 msg_mode = 1;
    wr(2'd1, 6'h3F); idle(2);
    chk("R7 quiet in message mode", int'(irq_level), 0);
    pulse_d(6'h28); idle(3);
    chk("R8 request raised", int'(msg_req), 1);
    chk("R8 lowest vector first", int'(msg_vec), 3);
    wr(2'd0, 6'h08);
    rd(2'd0, v); chk("R8 write does not clear in message mode", v, 'h28);
    chk("R8 request held without ack", int'(msg_req), 1);
    @(negedge clk); #1 msg_ack = 1;
    @(negedge clk); chk("R9 request drops after ack", int'(msg_req), 0);
    #1 msg_ack = 0;
    @(negedge clk); chk("R8 next request", int'(msg_req), 1);
    chk("R8 next vector", int'(msg_vec), 5);
    rd(2'd0, v); chk("R8 acked bit self-cleared", v, 'h20);
    auto_ack = 1; idle(4);
    rd(2'd0, v); chk("R8 all DMA bits drained", v, 0);
    // R8 / R6: user group message
    pulse_u(4'h8); idle(5);
    rd(2'd2, v); chk("R8 masked user bits self-cleared", v, 0);
    auto_ack = 0;
    pulse_u(4'h1); idle(4);
    chk("R6 no second user message before service", int'(msg_req), 0);
    rd(2'd2, v); chk("R6 later user event recorded", v, 'h1);
    // R5 in message mode
    wr(2'd1, 6'h00); pulse_d(6'h01); idle(3);
    chk("R5 masked DMA bit no request", int'(msg_req), 0);
    rd(2'd0, v); chk("R5 masked DMA bit recorded", v, 'h01);
    // random phase, compared against the model every clock
    rand_ack = 1;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk); #1;
      dma_evt   = DW'($urandom);
      if ($urandom % 4 == 0) usr_evt = UW'($urandom);
      reg_wr    = ($urandom % 6) == 0;
      reg_addr  = 2'($urandom);
      reg_wdata = RW'($urandom);
      if ($urandom % 200 == 0) msg_mode = ~msg_mode;
    end
    @(negedge clk); #1 reg_wr = 0; rand_ack = 0; msg_ack = 0;
    idle(4);
    report();
  end
endmodule